// File: doc/BRIEF.md
# Audio Port Bit and Frame Clock Generator

This block produces the bit clock and the left/right frame clock of an audio serial port that may act either as clock master or as clock slave. Everything runs from the master clock. The port becomes master when a strap pin or a mode bit is high. An active-low power-down input overrides both and forces the port to slave. As master, the block divides the master clock down to a 64fs bit clock and then to the frame clock, and it enables the clock output drivers. As slave, it turns off those drivers, drives its clock outputs low and watches the incoming frame clock.

A registered ready flag tells the converter when it may leave power-down. Three conditions must all hold: the power-down pin is high, the converter-enable bit is set, and the run (not-in-reset) bit is set. In addition, the port must either be master or, as slave, have locked onto a live incoming frame clock. A two-bit ratio input selects 256fs, 384fs, 512fs or 768fs. Any change of mode or ratio restarts both generated clocks from a clean, low phase.

Top module: `aclk_gen`

## Requirements
- R1: `clkOe` is high in the cycle after `pdnN & (modePin | modeBit)` is sampled high at a clock edge, and low in the cycle after it is sampled low. The pin and the bit are ORed.
- R2: While `pdnN` is low the port is slave. `clkOe` is low one cycle later, whatever `modePin` and `modeBit` say.
- R3: In slave mode `bclkOut` and `lrclkOut` are held low.
- R4: In master mode `bclkOut` divides the master clock with a 50% duty cycle. The divide ratio is 4, 6, 8 or 12 for `ratioSel` values 00, 01, 10 and 11 (256fs, 384fs, 512fs and 768fs). It starts low and first rises after half a period. `ratioSel` has no effect in slave mode.
- R5: In master mode `lrclkOut` has a period of 64 bit clocks and a 50% duty cycle. It starts low for the left channel, and it changes only on a falling edge of `bclkOut`.
- R6: A change of mode, or of `ratioSel` while master, restarts both clocks: both are low after that edge and the count starts from zero.
- R7: In slave mode, `lrclkIn` passes through a two-flop synchronizer. The frame clock counts as present once a second rising edge arrives within 1024 master clocks of the previous one.
- R8: In slave mode, 1024 master clocks without a rising edge on `lrclkIn` mark the frame clock as lost. `ready` then drops, and two new edges are needed to regain it.
- R9: `ready` is registered. It equals `pdnN & convEn & runBit & (master | present)` as sampled one edge earlier, and it is low during and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pdnN | input | 1 | Power-down pin, active low |
| modePin | input | 1 | Master-select strap pin |
| modeBit | input | 1 | Master-select register bit |
| ratioSel | input | 2 | Master clock to frame rate ratio select |
| convEn | input | 1 | Converter enable bit |
| runBit | input | 1 | Run bit, low holds the converter in reset |
| lrclkIn | input | 1 | Incoming frame clock (slave mode) |
| bclkOut | output | 1 | Generated bit clock |
| lrclkOut | output | 1 | Generated frame clock |
| clkOe | output | 1 | Output enable for the bit and frame clock drivers |
| ready | output | 1 | Converter may run |

## Verification
The hardest case to reach is the edge of the 1024-cycle lock window. Incoming edges spaced just over the window must never produce a lock. Edges spaced just under it must lock, and a stopped clock must unlock after exactly the window. The bench drives `lrclkIn` from a programmable half-period generator and sweeps it through a long period, a stopped clock and a period just inside the window. A cycle-exact model predicts `ready` on every edge. Mode and ratio changes are applied in the middle of the frame to exercise the restart.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  typedef struct packed {
    logic master;
    logic restart;
    logic bitToggle;
    logic frameToggle;
  } clkStrobe_t;
endpackage

// File: rtl/aclk_ctrl.sv
module aclk_ctrl
  import aclk_pkg::*;
#(
  parameter int BCLK_PER_FRAME = 64
) (
  input  logic       mclk,
  input  logic       rstN,
  input  logic       pdnN,
  input  logic       modePin,
  input  logic       modeBit,
  input  logic [1:0] ratioSel,
  output clkStrobe_t strobe,
  output logic       masterQ
);
  // toggles of the bit clock per frame-clock half period
  localparam int TOGS = BCLK_PER_FRAME;
  localparam int TW   = $clog2(TOGS);

  logic [1:0]    ratioQ;
  logic [2:0]    divCnt;
  logic [2:0]    halfLen;
  logic [TW-1:0] togCnt;

  always_comb begin
    // half period in master clocks: 2, 3, 4, 6
    halfLen = (ratioSel[0] ? 3'd3 : 3'd2) << ratioSel[1];
    strobe.master      = pdnN & (modePin | modeBit);
    strobe.restart     = (strobe.master != masterQ) || (ratioSel != ratioQ);
    strobe.bitToggle   = strobe.master && !strobe.restart && (divCnt == halfLen - 3'd1);
    strobe.frameToggle = strobe.bitToggle && (togCnt == TW'(TOGS - 1));
  end

  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) begin
      masterQ <= 1'b0;
      ratioQ  <= 2'b00;
      divCnt  <= '0;
      togCnt  <= '0;
    end else begin
      masterQ <= strobe.master;
      ratioQ  <= ratioSel;
      if (!strobe.master || strobe.restart) begin
        divCnt <= '0;
        togCnt <= '0;
      end else if (strobe.bitToggle) begin
        divCnt <= '0;
        togCnt <= strobe.frameToggle ? '0 : togCnt + 1'b1;
      end else begin
        divCnt <= divCnt + 3'd1;
      end
    end
  end
endmodule

// File: rtl/aclk_data.sv
module aclk_data
  import aclk_pkg::*;
#(
  parameter int LOCK_WIN = 1024
) (
  input  logic       mclk,
  input  logic       rstN,
  input  clkStrobe_t strobe,
  input  logic       pdnN,
  input  logic       convEn,
  input  logic       runBit,
  input  logic       lrclkIn,
  output logic       bclkOut,
  output logic       lrclkOut,
  output logic       ready
);
  localparam int WW = $clog2(LOCK_WIN + 1);

  logic [2:0]    syncQ;
  logic          riseSeen;
  logic [WW-1:0] winCnt;
  logic          seenOne;
  logic          present;

  assign riseSeen = syncQ[1] & ~syncQ[2];

  // generated clocks
  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) begin
      bclkOut  <= 1'b0;
      lrclkOut <= 1'b0;
    end else if (!strobe.master || strobe.restart) begin
      bclkOut  <= 1'b0;
      lrclkOut <= 1'b0;
    end else begin
      if (strobe.bitToggle)   bclkOut  <= ~bclkOut;
      if (strobe.frameToggle) lrclkOut <= ~lrclkOut;
    end
  end

  // incoming frame clock detector
  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      winCnt  <= '0;
      seenOne <= 1'b0;
      present <= 1'b0;
      ready   <= 1'b0;
    end else begin
      syncQ <= {syncQ[1:0], lrclkIn};
      ready <= pdnN & convEn & runBit & (strobe.master | present);
      if (strobe.master) begin
        winCnt  <= '0;
        seenOne <= 1'b0;
        present <= 1'b0;
      end else if (riseSeen) begin
        if (seenOne) present <= 1'b1;
        seenOne <= 1'b1;
        winCnt  <= '0;
      end else begin
        if (winCnt < WW'(LOCK_WIN)) winCnt <= winCnt + 1'b1;
        if (winCnt >= WW'(LOCK_WIN - 1)) begin
          present <= 1'b0;
          seenOne <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/aclk_gen.sv
module aclk_gen
  import aclk_pkg::*;
#(
  parameter int BCLK_PER_FRAME = 64,
  parameter int LOCK_WIN       = 1024
) (
  input  logic       mclk,
  input  logic       rstN,
  input  logic       pdnN,
  input  logic       modePin,
  input  logic       modeBit,
  input  logic [1:0] ratioSel,
  input  logic       convEn,
  input  logic       runBit,
  input  logic       lrclkIn,
  output logic       bclkOut,
  output logic       lrclkOut,
  output logic       clkOe,
  output logic       ready
);
  clkStrobe_t strobe;

  aclk_ctrl #(.BCLK_PER_FRAME(BCLK_PER_FRAME)) u_ctrl (
    .mclk(mclk), .rstN(rstN), .pdnN(pdnN), .modePin(modePin),
    .modeBit(modeBit), .ratioSel(ratioSel), .strobe(strobe), .masterQ(clkOe)
  );

  aclk_data #(.LOCK_WIN(LOCK_WIN)) u_data (
    .mclk(mclk), .rstN(rstN), .strobe(strobe), .pdnN(pdnN), .convEn(convEn),
    .runBit(runBit), .lrclkIn(lrclkIn), .bclkOut(bclkOut),
    .lrclkOut(lrclkOut), .ready(ready)
  );
endmodule

// File: rtl/aclk_gen_chk.sv
module aclk_gen_chk (
  input logic       mclk,
  input logic       rstN,
  input logic       pdnN,
  input logic       modePin,
  input logic       modeBit,
  input logic [1:0] ratioSel,
  input logic       convEn,
  input logic       runBit,
  input logic       bclkOut,
  input logic       lrclkOut,
  input logic       clkOe,
  input logic       ready
);
  // R2
  pdn_forces_slave_chk: assert property (@(posedge mclk) disable iff (!rstN)
    !pdnN |=> !clkOe);

  // R3
  slave_quiet_chk: assert property (@(posedge mclk) disable iff (!rstN)
    !clkOe |-> (!bclkOut && !lrclkOut));

  // R5
  frame_on_bit_fall_chk: assert property (@(posedge mclk) disable iff (!rstN)
    $rose(lrclkOut) |-> $fell(bclkOut));

  // R6
  ratio_restart_chk: assert property (@(posedge mclk) disable iff (!rstN)
    (pdnN && (modePin || modeBit) && !$stable(ratioSel)) |=> (!bclkOut && !lrclkOut));

  // R9
  ready_gate_chk: assert property (@(posedge mclk) disable iff (!rstN)
    ready |-> $past(pdnN && convEn && runBit));
endmodule

bind aclk_gen aclk_gen_chk u_chk (
  .mclk(mclk), .rstN(rstN), .pdnN(pdnN), .modePin(modePin), .modeBit(modeBit),
  .ratioSel(ratioSel), .convEn(convEn), .runBit(runBit), .bclkOut(bclkOut),
  .lrclkOut(lrclkOut), .clkOe(clkOe), .ready(ready)
);

// File: tb/tb_aclk_gen.sv
module tb_aclk_gen;
  logic       mclk = 1'b0;
  logic       rstN = 1'b0;
  logic       pdnN = 1'b0;
  logic       modePin = 1'b0;
  logic       modeBit = 1'b0;
  logic [1:0] ratioSel = 2'b00;
  logic       convEn = 1'b0;
  logic       runBit = 1'b0;
  logic       lrclkIn = 1'b0;
  logic       bclkOut, lrclkOut, clkOe, ready;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  aclk_gen dut (
    .mclk(mclk), .rstN(rstN), .pdnN(pdnN), .modePin(modePin), .modeBit(modeBit),
    .ratioSel(ratioSel), .convEn(convEn), .runBit(runBit), .lrclkIn(lrclkIn),
    .bclkOut(bclkOut), .lrclkOut(lrclkOut), .clkOe(clkOe), .ready(ready)
  );

  always #4 mclk = ~mclk;   // 125 MHz

  // programmable incoming frame clock: half period in master clocks, 0 = stopped
  int lrHalf = 0;
  int lrCnt = 0;
  always @(negedge mclk) begin
    if (lrHalf > 0) begin
      lrCnt = lrCnt + 1;
      if (lrCnt >= lrHalf) begin
        lrCnt = 0;
        lrclkIn = ~lrclkIn;
      end
    end
  end

  // behavioural reference, updated on every rising edge
  int  n = 0;
  bit  prevM = 0;
  int  prevR = 0;
  int  hist[$] = '{0, 0, 0};
  int  win = 0;
  bit  seen = 0;
  bit  pres = 0;
  bit  eReady = 0, eOe = 0, eB = 0, eL = 0;

  function automatic int halfOf(input int r);
    case (r)
      0: return 2;
      1: return 3;
      2: return 4;
      default: return 6;
    endcase
  endfunction

  always @(posedge mclk or negedge rstN) begin
    if (!rstN) begin
      n = 0; prevM = 0; prevR = 0; hist = '{0, 0, 0};
      win = 0; seen = 0; pres = 0;
      eReady = 0; eOe = 0; eB = 0; eL = 0;
    end else begin
      bit m;
      bit rise;
      m = pdnN & (modePin | modeBit);
      eReady = pdnN & convEn & runBit & (m | pres);
      // hist[1] is the older synchronized sample, hist[2] the one before it
      rise = (hist[1] == 1) && (hist[2] == 0);
      if (m) begin
        win = 0; seen = 0; pres = 0;
      end else if (rise) begin
        if (seen) pres = 1;
        seen = 1;
        win = 0;
      end else begin
        if (win >= 1023) begin pres = 0; seen = 0; end
        if (win < 1024) win = win + 1;
      end
      hist.push_front(int'(lrclkIn));
      void'(hist.pop_back());
      if (!m || m != prevM || int'(ratioSel) != prevR) n = 0;
      else n = n + 1;
      prevM = m;
      prevR = int'(ratioSel);
      eOe = m;
      eB = m ? (((n / halfOf(prevR)) % 2) == 1) : 1'b0;
      eL = m ? (((n / (halfOf(prevR) * 64)) % 2) == 1) : 1'b0;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, 2 ns after the rising edge
  always @(posedge mclk) begin
    #2;
    if (rstN && !finished) begin
      check("R1 clkOe", clkOe, eOe);
      check("R4 bclkOut", bclkOut, eB);
      check("R5 lrclkOut", lrclkOut, eL);
      check("R9 ready", ready, eReady);
    end
  end

  task automatic cycles(input int k);
    repeat (k) @(negedge mclk);
  endtask

  // sample 2 ns after the next rising edge
  task automatic afterEdge();
    @(posedge mclk);
    #2;
  endtask

  initial begin
    // reset state
    cycles(3);
    check("R9 reset ready", ready, 1'b0);
    check("R3 reset bclk", bclkOut, 1'b0);
    check("R1 reset oe", clkOe, 1'b0);
    rstN = 1'b1;
    pdnN = 1'b1; convEn = 1'b1; runBit = 1'b1;
    modePin = 1'b1;
    cycles(600);
    ratioSel = 2'd1; cycles(800);
    ratioSel = 2'd2;
    afterEdge();
    check("R6 restart bclk", bclkOut, 1'b0);
    check("R6 restart lrclk", lrclkOut, 1'b0);
    cycles(1100);
    ratioSel = 2'd3; cycles(1700);
    // OR of pin and bit: handover without a mode change
    modeBit = 1'b1; cycles(5);
    modePin = 1'b0; cycles(400);
    // power-down forces slave
    pdnN = 1'b0;
    cycles(3);
    check("R2 pdn oe", clkOe, 1'b0);
    check("R3 pdn bclk", bclkOut, 1'b0);
    cycles(50);
    pdnN = 1'b1; modeBit = 1'b0;
    // slave, live incoming frame clock
    lrHalf = 128;
    cycles(900);
    check("R7 lock", ready, 1'b1);
    ratioSel = 2'd0; cycles(300);
    check("R4 ratio ignored in slave", bclkOut, 1'b0);
    // stop the incoming clock
    lrHalf = 0;
    cycles(1300);
    check("R8 lost", ready, 1'b0);
    // edges spaced beyond the window never lock
    lrHalf = 600;
    cycles(5000);
    check("R8 sparse edges", ready, 1'b0);
    // edges spaced just inside the window lock
    lrHalf = 500;
    cycles(2500);
    check("R7 near-window lock", ready, 1'b1);
    convEn = 1'b0; cycles(5);
    check("R9 convEn gate", ready, 1'b0);
    convEn = 1'b1; runBit = 1'b0; cycles(5);
    check("R9 run gate", ready, 1'b0);
    runBit = 1'b1; cycles(5);
    // back to master in mid-stream
    modePin = 1'b1; ratioSel = 2'd1;
    cycles(900);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule